// File: doc/BRIEF.md
# Halt-Mode Power Sequencing Controller

This block steps a device into a deep halt low-power state and back out again. A halt request from the processor starts a drain window, during which the core clock keeps running so the pipeline and any pending work can finish. When that window ends, the block gates the core and peripheral clocks and turns the PLL off. The oscillator is turned off too, but only when the clock source chosen at entry is a crystal or resonator.

Waking up uses the two edges of one active-low wake pin. The falling edge re-enables the oscillator at once. This path does not wait for any clock edge, because the clocks are stopped. The rising edge, once synchronised, starts a counted PLL lock interval. After lock, the core clock comes back and a resume latency runs. The length of that latency depends on whether execution resumes from flash or from on-chip RAM. At the end, the block returns to normal and can pulse a wake interrupt.

Lock time and stability are modelled only as cycle counts of the free-running clock.

Top module: `halt_seq_ctrl`

## Requirements
- R1: A synchronous reset, applied in any state, puts the block in the normal state with `core_clk_en`, `periph_clk_en`, `pll_en` and `osc_en` all 1 and `wake_irq` 0.
- R2: A `halt_req` of 1 in the normal state moves the block to the flushing state on the next rising edge. The flushing state lasts exactly FLUSH_CYC cycles (default 32) with `core_clk_en` held at 1.
- R3: When flushing ends, the block enters the halted state with `core_clk_en`, `periph_clk_en` and `pll_en` all 0.
- R4: In the halted state, `osc_en` is 0 if `xtal_sel` was 1 (crystal) at halt entry, and 1 if it was 0 (external clock). `xtal_sel` and `flash_sel` are sampled only at halt entry; changing them later has no effect on the current sequence.
- R5: A falling edge on `wake_n` while halted raises `osc_en` without any clock edge. The state moves to oscillator-starting on the third rising clock edge after the fall, through a two-flop synchroniser.
- R6: A synchronised return of `wake_n` to 1 in the oscillator-starting state enters PLL-locking. PLL-locking lasts exactly LOCK_CYC cycles (default 131072) with `pll_en` 1 and `core_clk_en` 0.
- R7: After lock, the wake-latency state runs with `core_clk_en` 1. It lasts FLASH_LAT cycles (default 1125) when `flash_sel` was 1 at entry, and RAM_LAT cycles (default 35) when it was 0.
- R8: On return to normal, `wake_irq` is 1 for exactly the first normal cycle if `irq_en` is 1, and stays 0 if `irq_en` is 0.
- R9: A `halt_req` during the oscillator-starting, PLL-locking or wake-latency state is ignored: the sequence and its durations are unchanged.
- R10: `state` encodes normal=0, flushing=1, halted=2, oscillator-starting=3, PLL-locking=4, wake-latency=5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Halt request from the processor's idle instruction |
| xtal_sel | input | 1 | 1 = crystal/resonator source, 0 = external clock |
| flash_sel | input | 1 | 1 = resume from flash, 0 = resume from on-chip RAM |
| irq_en | input | 1 | Wake interrupt enable |
| wake_n | input | 1 | Active-low asynchronous wake pin |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| wake_irq | output | 1 | One-cycle wake interrupt pulse |
| state | output | 3 | Sequencer state code |

## Verification
The state follows `halt_req` one rising edge later. Every counted phase shows its code for exactly its configured number of cycles. The bench drives inputs on falling edges and counts consecutive falling-edge samples of each state code, so durations are checked exactly rather than within a window.

The oscillator enable is probed one time unit after the wake pin falls, before any rising edge occurs. After that fall, the halted code must persist for exactly two more samples. After the pin rises, the oscillator-starting code must do the same, which matches a two-flop synchroniser followed by the state register.

The interrupt pulse is checked in the first normal sample after wake latency and in the sample after it.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;

    typedef enum logic [2:0] {
        HS_NORMAL   = 3'd0,
        HS_FLUSH    = 3'd1,
        HS_HALTED   = 3'd2,
        HS_OSC_UP   = 3'd3,
        HS_PLL_LOCK = 3'd4,
        HS_WAKE_LAT = 3'd5
    } hs_state_e;

endpackage

// File: rtl/halt_sync2.sv
module halt_sync2 #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/halt_wake_edge.sv
// Captures a falling edge of the wake pin without needing the stopped clock.
module halt_wake_edge (
    input  logic wake_n,
    input  logic armed,
    input  logic clr,
    output logic fall_flag
);
    always_ff @(negedge wake_n or posedge clr) begin
        if (clr)        fall_flag <= 1'b0;
        else if (armed) fall_flag <= 1'b1;
    end
endmodule

// File: rtl/halt_seq_fsm.sv
module halt_seq_fsm
    import halt_seq_pkg::*;
#(
    parameter int FLUSH_CYC = 32,
    parameter int LOCK_CYC  = 131072,
    parameter int FLASH_LAT = 1125,
    parameter int RAM_LAT   = 35
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      halt_req,
    input  logic      xtal_sel,
    input  logic      flash_sel,
    input  logic      irq_en,
    input  logic      fall_sync,
    input  logic      wake_hi_sync,
    output hs_state_e state_o,
    output logic      xtal_o,
    output logic      clr_o,
    output logic      wake_irq
);
    localparam int MAX_A  = (FLUSH_CYC > LOCK_CYC) ? FLUSH_CYC : LOCK_CYC;
    localparam int MAX_B  = (FLASH_LAT > RAM_LAT) ? FLASH_LAT : RAM_LAT;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = $clog2(MAX_C) + 1;

    typedef struct packed {
        hs_state_e      st;
        logic [CW-1:0]  cnt;
        logic           xtal;
        logic           flash;
        logic           irq;
        logic           clr;
    } fsm_t;

    fsm_t          s_d, s_q;
    logic [CW-1:0] lat_last;

    always_comb begin
        lat_last = s_q.flash ? CW'(FLASH_LAT - 1) : CW'(RAM_LAT - 1);
        s_d      = s_q;
        s_d.irq  = 1'b0;
        unique case (s_q.st)
            HS_NORMAL: begin
                if (halt_req) begin
                    s_d.st    = HS_FLUSH;
                    s_d.cnt   = '0;
                    s_d.xtal  = xtal_sel;
                    s_d.flash = flash_sel;
                end
            end
            HS_FLUSH: begin
                if (s_q.cnt == CW'(FLUSH_CYC - 1)) begin
                    s_d.st  = HS_HALTED;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            HS_HALTED: begin
                if (fall_sync) s_d.st = HS_OSC_UP;
            end
            HS_OSC_UP: begin
                if (wake_hi_sync) begin
                    s_d.st  = HS_PLL_LOCK;
                    s_d.cnt = '0;
                end
            end
            HS_PLL_LOCK: begin
                if (s_q.cnt == CW'(LOCK_CYC - 1)) begin
                    s_d.st  = HS_WAKE_LAT;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            HS_WAKE_LAT: begin
                if (s_q.cnt == lat_last) begin
                    s_d.st  = HS_NORMAL;
                    s_d.cnt = '0;
                    s_d.irq = irq_en;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            default: s_d.st = HS_NORMAL;
        endcase
        s_d.clr = (s_d.st == HS_NORMAL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q       <= '0;
            s_q.st    <= HS_NORMAL;
            s_q.xtal  <= 1'b1;
            s_q.clr   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign state_o  = s_q.st;
    assign xtal_o   = s_q.xtal;
    assign clr_o    = s_q.clr;
    assign wake_irq = s_q.irq;

    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == HS_NORMAL && halt_req) |=> (s_q.st == HS_FLUSH)); // R2
    AST_FLUSH_BOUND: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == HS_FLUSH) |-> (s_q.cnt < CW'(FLUSH_CYC))); // R2
    AST_HALT_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.st == HS_HALTED) |-> ($past(s_q.st) == HS_FLUSH)); // R3
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (s_q.st != HS_NORMAL && $past(s_q.st) != HS_NORMAL) |-> ($stable(s_q.xtal) && $stable(s_q.flash))); // R4
    AST_LAT_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.st == HS_WAKE_LAT) |-> ($past(s_q.st) == HS_PLL_LOCK)); // R6
    AST_LOCK_BOUND: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == HS_PLL_LOCK) |-> (s_q.cnt < CW'(LOCK_CYC))); // R6
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wake_irq |=> !wake_irq); // R8
    AST_WAKE_NO_REHALT: assert property (@(posedge clk) disable iff (rst)
        (s_q.st inside {HS_OSC_UP, HS_PLL_LOCK, HS_WAKE_LAT} && halt_req) |=> (s_q.st != HS_FLUSH)); // R9
endmodule

// File: rtl/halt_seq_ctrl.sv
module halt_seq_ctrl
    import halt_seq_pkg::*;
#(
    parameter int FLUSH_CYC   = 32,
    parameter int LOCK_CYC    = 131072,
    parameter int FLASH_LAT   = 1125,
    parameter int RAM_LAT     = 35,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_req,
    input  logic       xtal_sel,
    input  logic       flash_sel,
    input  logic       irq_en,
    input  logic       wake_n,
    output logic       core_clk_en,
    output logic       periph_clk_en,
    output logic       pll_en,
    output logic       osc_en,
    output logic       wake_irq,
    output logic [2:0] state
);
    hs_state_e st;
    logic      xtal_q, clr_q, fall_flag, fall_sync, wake_hi_sync, armed;

    assign armed = (st == HS_HALTED);

    halt_wake_edge u_edge (
        .wake_n    (wake_n),
        .armed     (armed),
        .clr       (clr_q),
        .fall_flag (fall_flag)
    );

    halt_sync2 #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_fall (
        .clk (clk), .rst (rst), .d (fall_flag), .q (fall_sync)
    );

    halt_sync2 #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pin (
        .clk (clk), .rst (rst), .d (wake_n), .q (wake_hi_sync)
    );

    halt_seq_fsm #(
        .FLUSH_CYC (FLUSH_CYC),
        .LOCK_CYC  (LOCK_CYC),
        .FLASH_LAT (FLASH_LAT),
        .RAM_LAT   (RAM_LAT)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .halt_req     (halt_req),
        .xtal_sel     (xtal_sel),
        .flash_sel    (flash_sel),
        .irq_en       (irq_en),
        .fall_sync    (fall_sync),
        .wake_hi_sync (wake_hi_sync),
        .state_o      (st),
        .xtal_o       (xtal_q),
        .clr_o        (clr_q),
        .wake_irq     (wake_irq)
    );

    assign core_clk_en   = (st inside {HS_NORMAL, HS_FLUSH, HS_WAKE_LAT});
    assign periph_clk_en = (st inside {HS_NORMAL, HS_FLUSH, HS_WAKE_LAT});
    assign pll_en        = (st inside {HS_NORMAL, HS_FLUSH, HS_PLL_LOCK, HS_WAKE_LAT});
    // Oscillator stays on unless halted with a crystal; the raw edge flag wakes it at once.
    assign osc_en        = (st != HS_HALTED) || !xtal_q || fall_flag;
    assign state         = st;

    AST_OSC_WAKE: assert property (@(posedge clk) disable iff (rst)
        (st == HS_HALTED && fall_sync) |-> osc_en); // R5
    AST_CLK_OFF_IN_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(st == HS_PLL_LOCK) |-> ($past(st) == HS_OSC_UP)); // R6
endmodule

// File: tb/halt_seq_ctrl_bench.sv
module halt_seq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FLUSH_CYC  = 32;
    localparam int LOCK_CYC   = 300;
    localparam int FLASH_LAT  = 1125;
    localparam int RAM_LAT    = 35;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt_req = 1'b0, xtal_sel = 1'b1, flash_sel = 1'b0, irq_en = 1'b0, wake_n = 1'b1;
    logic core_clk_en, periph_clk_en, pll_en, osc_en, wake_irq;
    logic [2:0] state;

    int total = 0;
    int fails = 0;
    int cyc   = 0;

    halt_seq_ctrl #(
        .FLUSH_CYC (FLUSH_CYC), .LOCK_CYC (LOCK_CYC),
        .FLASH_LAT (FLASH_LAT), .RAM_LAT  (RAM_LAT)
    ) u_halt_seq_ctrl (
        .clk (clk), .rst (rst), .halt_req (halt_req), .xtal_sel (xtal_sel),
        .flash_sel (flash_sel), .irq_en (irq_en), .wake_n (wake_n),
        .core_clk_en (core_clk_en), .periph_clk_en (periph_clk_en),
        .pll_en (pll_en), .osc_en (osc_en), .wake_irq (wake_irq), .state (state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            total++; fails++;
            $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts consecutive falling-edge samples holding code st; optional halt pulse on sample 3.
    task automatic run_len(input logic [2:0] st, input bit inject, output int n);
        n = 0;
        while (state == st && n < 5000) begin
            n++;
            halt_req = (inject && n == 3);
            @(negedge clk);
        end
        halt_req = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(state == 3'd0, "R1 R10 reset state", state, 0);
        chk({core_clk_en, periph_clk_en, pll_en, osc_en} == 4'hF, "R1 enables after reset",
            {core_clk_en, periph_clk_en, pll_en, osc_en}, 15);
        chk(wake_irq == 1'b0, "R1 irq after reset", wake_irq, 0);
    endtask

    task automatic t_halt_wake(input bit xtal, input bit flash, input bit ien, input bit inject);
        int n;
        xtal_sel = xtal; flash_sel = flash; irq_en = ien;
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        chk(state == 3'd1, "R2 flush entry", state, 1);
        chk(core_clk_en == 1'b1, "R2 core clock on in flush", core_clk_en, 1);
        run_len(3'd1, 1'b0, n);
        chk(n == FLUSH_CYC, "R2 flush length", n, FLUSH_CYC);
        chk(state == 3'd2, "R3 R10 halted code", state, 2);
        chk({core_clk_en, periph_clk_en, pll_en} == 3'b000, "R3 clocks off in halt",
            {core_clk_en, periph_clk_en, pll_en}, 0);
        chk(osc_en == !xtal, "R4 osc in halt", osc_en, !xtal);
        xtal_sel = !xtal; flash_sel = !flash;
        repeat (5) @(negedge clk);
        chk(osc_en == !xtal && state == 3'd2, "R4 cfg change ignored", osc_en, !xtal);
        wake_n = 1'b0;
        #1;
        chk(osc_en == 1'b1, "R5 osc on without clock edge", osc_en, 1);
        @(negedge clk);
        run_len(3'd2, 1'b0, n);
        chk(n == 2, "R5 sync delay to osc start", n, 2);
        chk(state == 3'd3, "R5 R10 osc start code", state, 3);
        repeat (3) @(negedge clk);
        halt_req = inject;
        @(negedge clk);
        halt_req = 1'b0;
        chk(state == 3'd3, "R9 halt ignored while osc starts", state, 3);
        wake_n = 1'b1;
        @(negedge clk);
        run_len(3'd3, 1'b0, n);
        chk(n == 2, "R6 sync delay to lock", n, 2);
        chk(state == 3'd4 && pll_en && !core_clk_en, "R6 lock outputs",
            {state, pll_en, core_clk_en}, 'b10010);
        run_len(3'd4, inject, n);
        chk(n == LOCK_CYC, "R6 R9 lock length", n, LOCK_CYC);
        chk(state == 3'd5 && core_clk_en, "R7 core clock back in latency", {state, core_clk_en}, 'b1011);
        run_len(3'd5, inject, n);
        chk(n == (flash ? FLASH_LAT : RAM_LAT), "R7 R9 latency length", n, flash ? FLASH_LAT : RAM_LAT);
        chk(state == 3'd0, "R8 back to normal", state, 0);
        chk(wake_irq == ien, "R8 irq pulse", wake_irq, ien);
        @(negedge clk);
        chk(wake_irq == 1'b0, "R8 irq single cycle", wake_irq, 0);
    endtask

    task automatic t_reset_in_halt;
        int n;
        xtal_sel = 1'b1;
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        run_len(3'd1, 1'b0, n);
        chk(state == 3'd2 && !osc_en, "R4 halted with crystal", osc_en, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(state == 3'd0, "R1 reset from halt", state, 0);
        chk({core_clk_en, periph_clk_en, pll_en, osc_en} == 4'hF, "R1 enables after halt reset",
            {core_clk_en, periph_clk_en, pll_en, osc_en}, 15);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_halt_wake(1'b1, 1'b0, 1'b1, 1'b0);
        t_halt_wake(1'b0, 1'b1, 1'b0, 1'b1);
        t_halt_wake(1'b1, 1'b1, 1'b1, 1'b1);
        t_reset_in_halt();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule